// File: doc/BRIEF.md
# DLL Lock Timing Gate

This block sits between the command scheduler of a DDR SDRAM controller and the memory command bus. It watches each decoded command and keeps a record of whether the memory's delay-locked loop is running. It also counts how long ago the loop was last switched on. From that record it produces two permission flags. `read_ok` allows a read command. `nonread_ok` allows every other command.

A mode register set command aimed at the extended register is accepted only when every bank is idle. An accepted write loads the three low address bits into a local mirror:

- bit 0 turns the DLL on or off,
- bit 1 selects the output drive strength,
- bit 2 enables the optional bus-isolation output.

When any bank is open, the write is refused and the mirror keeps its old value. Entering self refresh switches the DLL off without any register write. Leaving self refresh switches it back on, provided the mirror still holds the enable value.

After each off-to-on change of the DLL, reads are held back for a fixed lock time. Non-read commands are held back for a shorter time, and that time depends on how the DLL was switched on. If a new enable event arrives while a wait is running, both waits start again from the beginning.

Top module: `dll_lock_gate`

## Requirements
- R1: When `cmd` is MRS (code 1) and `ba` = 2'b01 (bit 0 high, bit 1 low) with every `bank_open` bit low, `emr_mirror` takes the value of `addr[2:0]` in the next cycle. In `emr_mirror`, bit 0 is the DLL control, bit 1 is the drive strength and bit 2 is the isolation-output enable.
- R2: An MRS command with `ba` equal to 2'b00, 2'b10 or 2'b11 leaves `emr_mirror`, `read_ok` and `nonread_ok` unchanged and does not raise `emrs_reject`.
- R3: An extended register write presented while any `bank_open` bit is high raises `emrs_reject` in that same cycle. It leaves `emr_mirror` unchanged and opens neither gate.
- R4: After reset, `emr_mirror` is 3'b001 (DLL disabled, other fields 0) and `read_ok`, `nonread_ok` and `emrs_reject` are low. Both gates stay closed until an accepted write enables the DLL.
- R5: An accepted write with `addr[0]` equal to DLL_EN_VAL (default 0), made while the DLL is off, keeps `nonread_ok` low for MRD_WAIT (2) cycles after the command cycle and keeps `read_ok` low for RD_WAIT (200) cycles. Each flag rises in the cycle after its wait ends.
- R6: An accepted write with `addr[0]` not equal to DLL_EN_VAL drops `read_ok` in the next cycle. `read_ok` stays low for as long as the DLL remains off. `nonread_ok` is not affected.
- R7: Self refresh entry (code 2) drops both `read_ok` and `nonread_ok` in the next cycle. Both stay low until self refresh exit, and `emr_mirror` is left unchanged.
- R8: Self refresh exit (code 3) with the mirror's DLL bit at the enable value keeps `nonread_ok` low for XSR_WAIT (10) cycles after the exit cycle and keeps `read_ok` low for RD_WAIT (200) cycles.
- R9: A self refresh exit command given outside self refresh is ignored. An exit with the mirror's DLL bit at the disable value leaves `read_ok` low and lets `nonread_ok` rise in the next cycle.
- R10: An enable event while a wait is still running restarts both waits from the beginning of their full length.
- R11: An accepted write that enables the DLL while it is already on starts no new wait: `read_ok` and `nonread_ok` stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 3 | Decoded command: 0 idle, 1 MRS, 2 self refresh entry, 3 self refresh exit, 4-7 other commands |
| ba | input | 2 | Bank address bits sent with the command |
| addr | input | 3 | Address bits A2..A0 sent with the command |
| bank_open | input | NBANK | One bit per bank, high while that bank is open |
| read_ok | output | 1 | A read command may be issued |
| nonread_ok | output | 1 | A non-read command may be issued |
| emrs_reject | output | 1 | The extended register write in this cycle is refused |
| emr_mirror | output | 3 | Stored copy of the extended register: {isolation, drive, DLL} |

## Verification
A wrong DLL on/off state appears at `read_ok` in the cycle after the command that should have changed it. That shows most clearly after self refresh entry, or after a write that disables the DLL. A load value or decrement that is off by one moves the rising edge of a gate by exactly one cycle. The bench therefore records, for every enable event, the first cycle in which each flag is high and compares it with the full wait length. A restart that was missed shows as `read_ok` rising too early. A faulty decode or reject shows at `emr_mirror` one cycle after the command.

// File: rtl/dll_gate_pkg.sv
// Package: shared command codes and register layout for the DLL lock gate.
// Assumes the scheduler presents one decoded command per cycle.
package dll_gate_pkg;

    typedef enum logic [2:0] {
        CMD_NOP      = 3'd0,
        CMD_MRS      = 3'd1,
        CMD_SREF_IN  = 3'd2,
        CMD_SREF_OUT = 3'd3,
        CMD_ACT      = 3'd4,
        CMD_READ     = 3'd5,
        CMD_WRITE    = 3'd6,
        CMD_PRE      = 3'd7
    } ddr_cmd_e;

    typedef enum logic {
        SRC_MODE_WRITE = 1'b0,
        SRC_SREF_EXIT  = 1'b1
    } dll_src_e;

    typedef struct packed {
        logic qfc;
        logic drive;
        logic dll;
    } emr_fields_t;

endpackage

// File: rtl/dll_emr_decode.sv
// Module: decodes extended register writes, refuses them while a bank is
// open, and holds the mirrored register fields until the next accepted write.
// Assumes bank_open is valid in the same cycle as the command.
module dll_emr_decode
    import dll_gate_pkg::*;
#(
    parameter int NBANK      = 4,
    parameter bit DLL_EN_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ddr_cmd_e         cmd,
    input  logic [1:0]       ba,
    input  logic [2:0]       addr,
    input  logic [NBANK-1:0] bank_open,
    output logic             emrs_accept,
    output logic             emrs_reject,
    output emr_fields_t      emr_q
);

    localparam emr_fields_t EMR_RESET = '{qfc: 1'b0, drive: 1'b0, dll: ~DLL_EN_VAL};

    logic is_emrs;
    logic any_open;

    // Classify the command and apply the all-banks-idle rule.
    always_comb begin
        is_emrs     = (cmd == CMD_MRS) && (ba == 2'b01);
        any_open    = |bank_open;
        emrs_accept = is_emrs && !any_open;
        emrs_reject = is_emrs && any_open;
    end

    // Mirror register: loaded only by an accepted extended write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emr_q <= EMR_RESET;
        end else if (emrs_accept) begin
            emr_q <= emr_fields_t'(addr);
        end
    end

    p_accept_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
        emrs_accept |=> (emr_q == emr_fields_t'($past(addr))));

    p_other_mrs_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS && ba != 2'b01) |=> $stable(emr_q));

    p_reject_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        emrs_reject |=> $stable(emr_q));

endmodule

// File: rtl/dll_state_track.sv
// Module: follows the DLL on/off state across extended writes and self
// refresh, and flags each off-to-on change together with its cause.
// Assumes no extended write is issued while in self refresh.
module dll_state_track
    import dll_gate_pkg::*;
#(
    parameter bit DLL_EN_VAL = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  ddr_cmd_e cmd,
    input  logic     emrs_accept,
    input  logic     new_dll,
    input  logic     stored_dll,
    output logic     dll_on,
    output logic     in_sref,
    output logic     armed,
    output logic     en_evt,
    output dll_src_e en_src
);

    logic want_on;
    logic by_write;
    logic sref_enter;
    logic sref_leave;
    logic by_exit;

    // Work out which enable event, if any, this command causes.
    always_comb begin
        want_on    = (new_dll == DLL_EN_VAL);
        by_write   = emrs_accept && want_on && !dll_on;
        sref_enter = (cmd == CMD_SREF_IN) && !in_sref;
        sref_leave = (cmd == CMD_SREF_OUT) && in_sref;
        by_exit    = sref_leave && (stored_dll == DLL_EN_VAL);
        en_evt     = by_write || by_exit;
        en_src     = by_exit ? SRC_SREF_EXIT : SRC_MODE_WRITE;
    end

    // State update for DLL on/off, self refresh and the first-enable flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dll_on  <= 1'b0;
            in_sref <= 1'b0;
            armed   <= 1'b0;
        end else begin
            if (emrs_accept) begin
                dll_on <= want_on;
            end
            if (sref_enter) begin
                in_sref <= 1'b1;
                dll_on  <= 1'b0;
            end
            if (sref_leave) begin
                in_sref <= 1'b0;
                dll_on  <= (stored_dll == DLL_EN_VAL);
            end
            armed <= armed || en_evt;
        end
    end

    p_sref_in_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_SREF_IN) |=> (!dll_on && in_sref));

    p_stray_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_SREF_OUT && !in_sref) |=> ($stable(dll_on) && !in_sref));

    p_event_from_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        en_evt |-> !dll_on);

endmodule

// File: rtl/dll_wait_counter.sv
// Module: down counter that is reloaded by an event and reports done at zero.
// Assumes load_val never exceeds MAX.
module dll_wait_counter #(
    parameter int MAX = 200,
    parameter int W   = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    // Reload on an event, otherwise count down until zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Wait is over once the counter reaches zero.
    always_comb begin
        done = (cnt == '0);
    end

    p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

    p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= MAX);

endmodule

// File: rtl/dll_lock_gate.sv
// Module: top of the DLL lock gate. It combines the register decode, the DLL
// state tracker and the two wait counters into the read and non-read flags.
// Assumes one command per cycle and at least one wait cycle for each gate.
module dll_lock_gate
    import dll_gate_pkg::*;
#(
    parameter int NBANK      = 4,
    parameter int RD_WAIT    = 200,
    parameter int MRD_WAIT   = 2,
    parameter int XSR_WAIT   = 10,
    parameter bit DLL_EN_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd,
    input  logic [1:0]       ba,
    input  logic [2:0]       addr,
    input  logic [NBANK-1:0] bank_open,
    output logic             read_ok,
    output logic             nonread_ok,
    output logic             emrs_reject,
    output logic [2:0]       emr_mirror
);

    localparam int NR_MAX = (MRD_WAIT > XSR_WAIT) ? MRD_WAIT : XSR_WAIT;
    localparam int RD_W   = $clog2(RD_WAIT + 1);
    localparam int NR_W   = $clog2(NR_MAX + 1);

    ddr_cmd_e    cmd_e;
    logic        emrs_accept;
    emr_fields_t emr_q;
    logic        dll_on;
    logic        in_sref;
    logic        armed;
    logic        en_evt;
    dll_src_e    en_src;
    logic        rd_done;
    logic        nr_done;
    logic [NR_W-1:0] nr_load;

    // Give the raw command bits their enumerated meaning.
    always_comb begin
        cmd_e = ddr_cmd_e'(cmd);
    end

    dll_emr_decode #(
        .NBANK      (NBANK),
        .DLL_EN_VAL (DLL_EN_VAL)
    ) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd_e),
        .ba          (ba),
        .addr        (addr),
        .bank_open   (bank_open),
        .emrs_accept (emrs_accept),
        .emrs_reject (emrs_reject),
        .emr_q       (emr_q)
    );

    dll_state_track #(
        .DLL_EN_VAL (DLL_EN_VAL)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd_e),
        .emrs_accept (emrs_accept),
        .new_dll     (addr[0]),
        .stored_dll  (emr_q.dll),
        .dll_on      (dll_on),
        .in_sref     (in_sref),
        .armed       (armed),
        .en_evt      (en_evt),
        .en_src      (en_src)
    );

    // The non-read wait length depends on how the DLL was switched on.
    always_comb begin
        nr_load = (en_src == SRC_SREF_EXIT) ? NR_W'(XSR_WAIT) : NR_W'(MRD_WAIT);
    end

    dll_wait_counter #(
        .MAX (RD_WAIT),
        .W   (RD_W)
    ) u_rd_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (en_evt),
        .load_val (RD_W'(RD_WAIT)),
        .done     (rd_done)
    );

    dll_wait_counter #(
        .MAX (NR_MAX),
        .W   (NR_W)
    ) u_nr_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (en_evt),
        .load_val (nr_load),
        .done     (nr_done)
    );

    // Combine the DLL state with the wait counters into the two flags.
    always_comb begin
        read_ok    = dll_on && rd_done;
        nonread_ok = armed && !in_sref && nr_done;
        emr_mirror = emr_q;
    end

    p_event_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en_evt |=> (!read_ok && !nonread_ok));

    p_disable_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (emrs_accept && addr[0] != DLL_EN_VAL) |=> !read_ok);

    p_sref_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_e == CMD_SREF_IN) |=> (!read_ok && !nonread_ok));

endmodule

// File: tb/dll_lock_gate_test.sv
module dll_lock_gate_test;

    localparam int CLK_PERIOD = 10;
    localparam int NBANK      = 4;
    localparam int RD_WAIT    = 200;
    localparam int MRD_WAIT   = 2;
    localparam int XSR_WAIT   = 10;

    localparam logic [2:0] C_NOP = 3'd0;
    localparam logic [2:0] C_MRS = 3'd1;
    localparam logic [2:0] C_SIN = 3'd2;
    localparam logic [2:0] C_SOUT = 3'd3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cmd = C_NOP;
    logic [1:0]       ba = 2'b00;
    logic [2:0]       addr = 3'b000;
    logic [NBANK-1:0] bank_open = '0;
    logic             read_ok;
    logic             nonread_ok;
    logic             emrs_reject;
    logic [2:0]       emr_mirror;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    dll_lock_gate #(
        .NBANK    (NBANK),
        .RD_WAIT  (RD_WAIT),
        .MRD_WAIT (MRD_WAIT),
        .XSR_WAIT (XSR_WAIT)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .ba          (ba),
        .addr        (addr),
        .bank_open   (bank_open),
        .read_ok     (read_ok),
        .nonread_ok  (nonread_ok),
        .emrs_reject (emrs_reject),
        .emr_mirror  (emr_mirror)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Present a command for one cycle; returns in the cycle after it.
    task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic [2:0] a);
        @(negedge clk);
        cmd = c;
        ba = b;
        addr = a;
        @(negedge clk);
        cmd = C_NOP;
        ba = 2'b00;
        addr = 3'b000;
    endtask

    // Starting in the cycle after an event, find the first cycle each flag is high.
    task automatic profile(input string tag, input int exp_nr, input int exp_rd);
        int nr_first = 0;
        int rd_first = 0;
        for (int i = 1; i <= RD_WAIT + 6; i++) begin
            if (nonread_ok && nr_first == 0) nr_first = i;
            if (read_ok && rd_first == 0) rd_first = i;
            @(negedge clk);
        end
        chk({tag, " nonread_ok first high cycle"}, nr_first, exp_nr);
        chk({tag, " read_ok first high cycle"}, rd_first, exp_rd);
    endtask

    // Count the cycles each flag is high over n cycles, starting with the current one.
    task automatic watch(input int n, output int rd_hi, output int nr_hi);
        rd_hi = 0;
        nr_hi = 0;
        for (int i = 0; i < n; i++) begin
            if (read_ok) rd_hi++;
            if (nonread_ok) nr_hi++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int rh;
        int nh;
        chk("R4 mirror after reset", int'(emr_mirror), 1);
        chk("R4 read_ok after reset", int'(read_ok), 0);
        chk("R4 nonread_ok after reset", int'(nonread_ok), 0);
        chk("R4 emrs_reject after reset", int'(emrs_reject), 0);
        watch(30, rh, nh);
        chk("R4 read_ok stays closed", rh, 0);
        chk("R4 nonread_ok stays closed", nh, 0);
    endtask

    task automatic t_other_mrs();
        int rh;
        int nh;
        for (int b = 0; b < 4; b++) begin
            if (b == 1) continue;
            @(negedge clk);
            cmd = C_MRS;
            ba = 2'(b);
            addr = 3'b110;
            #1;
            chk("R2 no reject for other register", int'(emrs_reject), 0);
            @(negedge clk);
            cmd = C_NOP;
            chk("R2 mirror unchanged", int'(emr_mirror), 1);
        end
        watch(5, rh, nh);
        chk("R2 gates stay closed", rh + nh, 0);
    endtask

    task automatic t_reject();
        int rh;
        int nh;
        @(negedge clk);
        bank_open = 4'b0100;
        cmd = C_MRS;
        ba = 2'b01;
        addr = 3'b110;
        #1;
        chk("R3 reject with open bank", int'(emrs_reject), 1);
        @(negedge clk);
        cmd = C_NOP;
        bank_open = '0;
        #1;
        chk("R3 reject clears", int'(emrs_reject), 0);
        chk("R3 mirror unchanged", int'(emr_mirror), 1);
        watch(10, rh, nh);
        chk("R3 gates stay closed", rh + nh, 0);
    endtask

    task automatic t_enable_write();
        @(negedge clk);
        cmd = C_MRS;
        ba = 2'b01;
        addr = 3'b110;
        #1;
        chk("R1 no reject when idle", int'(emrs_reject), 0);
        @(negedge clk);
        cmd = C_NOP;
        addr = 3'b000;
        ba = 2'b00;
        chk("R1 mirror loaded", int'(emr_mirror), 6);
        profile("R5 enable by write", MRD_WAIT + 1, RD_WAIT + 1);
    endtask

    task automatic t_enable_again();
        int rh;
        int nh;
        issue(C_MRS, 2'b01, 3'b100);
        chk("R11 mirror loaded", int'(emr_mirror), 4);
        watch(20, rh, nh);
        chk("R11 read_ok stays high", rh, 20);
        chk("R11 nonread_ok stays high", nh, 20);
    endtask

    task automatic t_disable();
        int rh;
        int nh;
        issue(C_MRS, 2'b01, 3'b001);
        chk("R6 read_ok drops", int'(read_ok), 0);
        chk("R6 nonread_ok kept", int'(nonread_ok), 1);
        chk("R6 mirror loaded", int'(emr_mirror), 1);
        watch(RD_WAIT + 20, rh, nh);
        chk("R6 read_ok stays low", rh, 0);
        chk("R6 nonread_ok stays high", nh, RD_WAIT + 20);
    endtask

    task automatic t_restart();
        int rh;
        int nh;
        issue(C_MRS, 2'b01, 3'b000);
        watch(50, rh, nh);
        chk("R10 read_ok low mid-wait", rh, 0);
        issue(C_MRS, 2'b01, 3'b001);
        issue(C_MRS, 2'b01, 3'b000);
        profile("R10 restart by write", MRD_WAIT + 1, RD_WAIT + 1);
    endtask

    task automatic t_sref();
        int rh;
        int nh;
        issue(C_SIN, 2'b00, 3'b000);
        chk("R7 read_ok drops", int'(read_ok), 0);
        chk("R7 nonread_ok drops", int'(nonread_ok), 0);
        chk("R7 mirror unchanged", int'(emr_mirror), 0);
        watch(20, rh, nh);
        chk("R7 gates low in self refresh", rh + nh, 0);
        issue(C_SOUT, 2'b00, 3'b000);
        profile("R8 enable by exit", XSR_WAIT + 1, RD_WAIT + 1);
        issue(C_SIN, 2'b00, 3'b000);
        issue(C_SOUT, 2'b00, 3'b000);
        watch(100, rh, nh);
        issue(C_SIN, 2'b00, 3'b000);
        issue(C_SOUT, 2'b00, 3'b000);
        profile("R10 restart by exit", XSR_WAIT + 1, RD_WAIT + 1);
    endtask

    task automatic t_stray();
        int rh;
        int nh;
        issue(C_SOUT, 2'b00, 3'b000);
        watch(5, rh, nh);
        chk("R9 stray exit read_ok kept", rh, 5);
        chk("R9 stray exit nonread_ok kept", nh, 5);
        issue(C_MRS, 2'b01, 3'b001);
        issue(C_SIN, 2'b00, 3'b000);
        issue(C_SOUT, 2'b00, 3'b000);
        chk("R9 nonread_ok after exit with DLL off", int'(nonread_ok), 1);
        watch(RD_WAIT + 10, rh, nh);
        chk("R9 read_ok stays low with DLL off", rh, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_other_mrs();
        t_reject();
        t_enable_write();
        t_enable_again();
        t_disable();
        t_restart();
        t_sref();
        t_stray();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule